// File: doc/BRIEF.md
# VME Interrupt Level Status and Acknowledge Unit

This block sits between the host read path of a bus bridge and the seven active-low VME interrupt request lines. Each level is synchronised and latched. A read-only status word tells the host whether any level is pending and which pending level is the highest. The status word is built so that the host adds it to the acknowledge region's base address and gets the address of the byte it must read to acknowledge that level. No shift or mask is needed.

A byte read at an odd offset in the acknowledge region starts an interrupt-acknowledge cycle on the bus side for the matching level. The request and level are held until the bus side reports completion. The returned 8-bit vector then goes back to the host in the low data byte.

A second section collects local events and reports each one under a fixed vector number:
- The front-panel button is taken on its falling edge.
- The other events are taken on rising edges.
- A bus error or bus timeout also drives a dedicated local level-7 flag.
- The button also drives a dedicated local level-6 flag.

Top module: `vme_irq_ack`

## Requirements
- R1: After reset no level is pending. `irq_any` is 0, and `loc_pend`, `loc_l6`, `loc_l7` and `iack_req` are 0. A level whose line `vme_irq_n[L-1]` is driven low becomes pending, and `irq_any` goes to 1.
- R2: A read at offset `STAT_OFS` (0x0004) returns the status word. Bit 0 is 1 when any level is pending. Bits 3..1 hold the highest pending level (1..7). Bits 15..4 are 0. With nothing pending the word is 0.
- R3: Level 7 has the highest priority, and among pending levels the larger number wins.
- R4: A byte read (`rd_byte`=1) at offset 0x0800 + 2L + 1 for L in 1..7 raises `iack_req` with `iack_lvl`=L. Both are held unchanged until `iack_done` is seen.
- R5: In the cycle after `iack_done`, `rd_ack` pulses. `rd_data[7:0]` carries `iack_vec` and `rd_data[15:8]` is 0.
- R6: The acknowledge address of the highest pending level equals 0x0800 plus the status word.
- R7: A pending level stays pending while its line is still low after its acknowledge. It also stays pending after its line is released, as long as no acknowledge has completed. It clears once both its acknowledge has completed and its line is high.
- R8: The following reads start no acknowledge cycle and return 0 in the next cycle:
  - word reads in the acknowledge region;
  - byte reads at even offsets there;
  - byte reads at odd offsets beyond level 7;
  - reads at any other offset except `STAT_OFS`.
- R9: Local events report these vector numbers on `loc_vec`:
  - `host_tmo` 1, `tick` 2, button 6, `bus_err` 7;
  - `gsw[0..3]` 8..11, `msw[0..3]` 12..15;
  - `acfail` 16, `wpfail` 17, `arb_tmo` 18, `sysfail` 19.
- R10: The button (`btn_n`) registers only on a falling edge, and sets `loc_l6`. A rising edge has no effect. `bus_err` sets `loc_l7`.
- R11: With several local events pending, `loc_vec` shows the lowest vector number. A `loc_clr` pulse clears only that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vme_irq_n | input | 7 | Interrupt request lines, bit L-1 is level L, active low |
| rd_stb | input | 1 | Host read request, one cycle |
| rd_byte | input | 1 | 1 = byte read, 0 = word read |
| rd_addr | input | 13 | Host read offset |
| rd_ack | output | 1 | Read data valid, one cycle |
| rd_data | output | 16 | Read data |
| irq_any | output | 1 | Any level pending |
| iack_req | output | 1 | Acknowledge cycle request to the bus side |
| iack_lvl | output | 3 | Level being acknowledged |
| iack_done | input | 1 | Bus side finished the acknowledge cycle |
| iack_vec | input | 8 | Vector byte from the acknowledge cycle |
| host_tmo | input | 1 | Host access timeout event |
| tick | input | 1 | Clock tick event |
| btn_n | input | 1 | Front-panel button, active low |
| bus_err | input | 1 | Bus error or bus timeout event |
| gsw | input | 4 | Global interprocess switch events |
| msw | input | 4 | Module interprocess switch events |
| acfail | input | 1 | AC failure event |
| wpfail | input | 1 | Posted-write failure event |
| arb_tmo | input | 1 | Arbitration timeout event |
| sysfail | input | 1 | System failure event |
| loc_clr | input | 1 | Clear the local event shown on `loc_vec` |
| loc_pend | output | 1 | Any local event pending |
| loc_vec | output | 8 | Vector number of the reported local event |
| loc_l6 | output | 1 | Button event pending (local level 6) |
| loc_l7 | output | 1 | Bus error event pending (local level 7) |

## Verification
The checker watches several properties every cycle:
- the status word keeps its shape against the latched pending bits;
- level 7 always wins;
- an acknowledge request keeps its level until completion, and its vector comes back one cycle later with a clean upper byte;
- a reported local vector is always a legal number.

Some properties are visible only as sequences over many cycles, so only the bench scenarios show them:
- the conditions under which a level clears;
- the status-plus-base addressing;
- the rejection of even, word and out-of-range reads;
- the edge sensitivity of the button;
- the lowest-first order of local events.

// File: rtl/vme_irq_pkg.sv
package vme_irq_pkg;

   typedef enum logic [0:0] {
      HST_IDLE = 1'b0,
      HST_IACK = 1'b1
   } hst_state_e;

   // fixed vector number for a local event index: 0,1 -> 1,2 ; 2.. -> 6..
   function automatic logic [7:0] loc_vec_of(input logic [4:0] idx);
      if (idx < 5'd2)
         return 8'(idx) + 8'd1;
      else
         return 8'(idx) + 8'd4;
   endfunction

endpackage

// File: rtl/irq_level_latch.sv
module irq_level_latch #(
   parameter int NUM_LEVELS  = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] irq_n,
   input  logic [NUM_LEVELS-1:0] ack_pulse,
   output logic [NUM_LEVELS-1:0] pend
);

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      logic req;
      logic pend_q;
      logic acked_q;

      if (SYNC_STAGES == 0) begin : g_nosync
         assign req = ~irq_n[g];
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= irq_n[g];
               for (int k = 1; k < SYNC_STAGES; k++)
                  sh_q[k] <= sh_q[k-1];
            end
         end
         assign req = ~sh_q[SYNC_STAGES-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q  <= 1'b0;
            acked_q <= 1'b0;
         end else begin
            pend_q  <= req | (pend_q & ~(acked_q | ack_pulse[g]));
            acked_q <= (acked_q | ack_pulse[g]) & req;
         end
      end

      assign pend[g] = pend_q;
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_LEVELS = 7,
   parameter int DATA_W     = 16,
   localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
   input  logic [NUM_LEVELS-1:0] pend,
   output logic [DATA_W-1:0]     status
);

   logic [LVL_W-1:0] top_lvl;

   always_comb begin
      top_lvl = '0;
      for (int k = 0; k < NUM_LEVELS; k++)
         if (pend[k]) top_lvl = LVL_W'(k + 1);
   end

   always_comb begin
      status = '0;
      status[0] = |pend;
      status[LVL_W:1] = top_lvl;
   end

endmodule

// File: rtl/loc_evt_unit.sv
module loc_evt_unit
   import vme_irq_pkg::*;
#(
   parameter int LOC_N = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOC_N-1:0] raw,
   input  logic             clr,
   output logic             pend_any,
   output logic [7:0]       vec,
   output logic [LOC_N-1:0] pend
);

   logic [LOC_N-1:0] prev_q;
   logic [LOC_N-1:0] pend_q;
   logic [LOC_N-1:0] clr_mask;
   logic [4:0]       sel;

   always_comb begin
      sel = '0;
      for (int k = LOC_N - 1; k >= 0; k--)
         if (pend_q[k]) sel = 5'(k);
   end

   always_comb begin
      clr_mask = '0;
      if (clr && (|pend_q)) clr_mask[sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '1;
         pend_q <= '0;
      end else begin
         prev_q <= raw;
         pend_q <= (pend_q & ~clr_mask) | (raw & ~prev_q);
      end
   end

   assign pend_any = |pend_q;
   assign vec      = pend_any ? loc_vec_of(sel) : 8'd0;
   assign pend     = pend_q;

endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
   import vme_irq_pkg::*;
#(
   parameter int              NUM_LEVELS = 7,
   parameter int              ADDR_W     = 13,
   parameter int              DATA_W     = 16,
   parameter logic [ADDR_W-1:0] ACK_BASE = 13'h0800,
   parameter logic [ADDR_W-1:0] STAT_OFS = 13'h0004,
   localparam int             LVL_W      = $clog2(NUM_LEVELS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_stb,
   input  logic                  rd_byte,
   input  logic [ADDR_W-1:0]     rd_addr,
   input  logic [DATA_W-1:0]     status,
   output logic                  rd_ack,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  iack_req,
   output logic [LVL_W-1:0]      iack_lvl,
   input  logic                  iack_done,
   input  logic [7:0]            iack_vec,
   output logic [NUM_LEVELS-1:0] ack_pulse
);

   hst_state_e          state_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [ADDR_W-1:0]   off;
   logic [ADDR_W-2:0]   cand;
   logic                hit_ack;

   assign off  = rd_addr - ACK_BASE;
   assign cand = off[ADDR_W-1:1];
   assign hit_ack = rd_byte && (rd_addr >= ACK_BASE) && off[0]
                    && (cand != '0) && (cand <= (ADDR_W-1)'(NUM_LEVELS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= HST_IDLE;
         lvl_q   <= '0;
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= 1'b0;
         case (state_q)
            HST_IDLE: begin
               if (rd_stb) begin
                  if (hit_ack) begin
                     state_q <= HST_IACK;
                     lvl_q   <= LVL_W'(cand);
                  end else begin
                     rd_ack  <= 1'b1;
                     rd_data <= (rd_addr == STAT_OFS) ? status : '0;
                  end
               end
            end
            HST_IACK: begin
               if (iack_done) begin
                  state_q <= HST_IDLE;
                  rd_ack  <= 1'b1;
                  rd_data <= DATA_W'(iack_vec);
               end
            end
            default: state_q <= HST_IDLE;
         endcase
      end
   end

   assign iack_req = (state_q == HST_IACK);
   assign iack_lvl = iack_req ? lvl_q : '0;

   always_comb begin
      ack_pulse = '0;
      for (int k = 0; k < NUM_LEVELS; k++)
         if (iack_req && iack_done && (lvl_q == LVL_W'(k + 1)))
            ack_pulse[k] = 1'b1;
   end

endmodule

// File: rtl/vme_irq_ack.sv
module vme_irq_ack #(
   parameter int              NUM_LEVELS  = 7,
   parameter int              SYNC_STAGES = 2,
   parameter int              ADDR_W      = 13,
   parameter int              DATA_W      = 16,
   parameter logic [ADDR_W-1:0] ACK_BASE  = 13'h0800,
   parameter logic [ADDR_W-1:0] STAT_OFS  = 13'h0004,
   localparam int             LVL_W       = $clog2(NUM_LEVELS + 1),
   localparam int             LOC_N       = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] vme_irq_n,
   input  logic                  rd_stb,
   input  logic                  rd_byte,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic                  rd_ack,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  irq_any,
   output logic                  iack_req,
   output logic [LVL_W-1:0]      iack_lvl,
   input  logic                  iack_done,
   input  logic [7:0]            iack_vec,
   input  logic                  host_tmo,
   input  logic                  tick,
   input  logic                  btn_n,
   input  logic                  bus_err,
   input  logic [3:0]            gsw,
   input  logic [3:0]            msw,
   input  logic                  acfail,
   input  logic                  wpfail,
   input  logic                  arb_tmo,
   input  logic                  sysfail,
   input  logic                  loc_clr,
   output logic                  loc_pend,
   output logic [7:0]            loc_vec,
   output logic                  loc_l6,
   output logic                  loc_l7
);

   if (NUM_LEVELS < 1 || NUM_LEVELS > 7) begin : g_bad_levels
      $error("NUM_LEVELS must be 1..7 to fit status bits 3..1");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold at least the vector byte");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic [NUM_LEVELS-1:0] pend_q;
   logic [NUM_LEVELS-1:0] ack_pulse;
   logic [DATA_W-1:0]     stat_w;
   logic [LOC_N-1:0]      loc_raw;
   logic [LOC_N-1:0]      loc_pend_v;

   irq_level_latch #(
      .NUM_LEVELS (NUM_LEVELS),
      .SYNC_STAGES(SYNC_STAGES)
   ) i_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_n    (vme_irq_n),
      .ack_pulse(ack_pulse),
      .pend     (pend_q)
   );

   irq_prio_enc #(
      .NUM_LEVELS(NUM_LEVELS),
      .DATA_W    (DATA_W)
   ) i_enc (
      .pend  (pend_q),
      .status(stat_w)
   );

   iack_ctrl #(
      .NUM_LEVELS(NUM_LEVELS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ACK_BASE  (ACK_BASE),
      .STAT_OFS  (STAT_OFS)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_stb),
      .rd_byte  (rd_byte),
      .rd_addr  (rd_addr),
      .status   (stat_w),
      .rd_ack   (rd_ack),
      .rd_data  (rd_data),
      .iack_req (iack_req),
      .iack_lvl (iack_lvl),
      .iack_done(iack_done),
      .iack_vec (iack_vec),
      .ack_pulse(ack_pulse)
   );

   // event index order sets the vector number (see package function)
   assign loc_raw = {sysfail, arb_tmo, wpfail, acfail, msw, gsw,
                     bus_err, ~btn_n, tick, host_tmo};

   loc_evt_unit #(
      .LOC_N(LOC_N)
   ) i_loc (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (loc_raw),
      .clr     (loc_clr),
      .pend_any(loc_pend),
      .vec     (loc_vec),
      .pend    (loc_pend_v)
   );

   assign irq_any = |pend_q;
   assign loc_l6  = loc_pend_v[2];
   assign loc_l7  = loc_pend_v[3];

endmodule

// File: rtl/vme_irq_ack_chk.sv
module vme_irq_ack_chk #(
   parameter int NUM_LEVELS = 7,
   parameter int DATA_W     = 16,
   localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  iack_req,
   input logic                  iack_done,
   input logic [LVL_W-1:0]      iack_lvl,
   input logic [7:0]            iack_vec,
   input logic                  rd_ack,
   input logic [DATA_W-1:0]     rd_data,
   input logic [NUM_LEVELS-1:0] pend,
   input logic [DATA_W-1:0]     status,
   input logic                  loc_pend,
   input logic [7:0]            loc_vec
);

   AST_IACK_LEVEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      iack_req |-> (iack_lvl != '0) && (iack_lvl <= LVL_W'(NUM_LEVELS))); // R4
   AST_IACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_req && !iack_done) |=> (iack_req && $stable(iack_lvl))); // R4
   AST_VEC_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_req && iack_done) |=> (rd_ack && rd_data == DATA_W'($past(iack_vec)))); // R5
   AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status[DATA_W-1:4] == '0); // R2
   AST_STAT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend) == status[0]); // R2
   AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      pend[NUM_LEVELS-1] |-> (status[3:1] == 3'(NUM_LEVELS))); // R3
   AST_LOC_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      loc_pend |-> ((loc_vec >= 8'd1 && loc_vec <= 8'd2) ||
                    (loc_vec >= 8'd6 && loc_vec <= 8'd19))); // R9

endmodule

bind vme_irq_ack vme_irq_ack_chk #(
   .NUM_LEVELS(NUM_LEVELS),
   .DATA_W    (DATA_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iack_req (iack_req),
   .iack_done(iack_done),
   .iack_lvl (iack_lvl),
   .iack_vec (iack_vec),
   .rd_ack   (rd_ack),
   .rd_data  (rd_data),
   .pend     (pend_q),
   .status   (stat_w),
   .loc_pend (loc_pend),
   .loc_vec  (loc_vec)
);

// File: tb/test_vme_irq_ack.sv
module test_vme_irq_ack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  vme_irq_n = '1;
   logic        rd_stb = 1'b0, rd_byte = 1'b0;
   logic [12:0] rd_addr = '0;
   logic        rd_ack;
   logic [15:0] rd_data;
   logic        irq_any, iack_req;
   logic [2:0]  iack_lvl;
   logic        iack_done = 1'b0;
   logic [7:0]  iack_vec = '0;
   logic        host_tmo = 0, tick = 0, btn_n = 1, bus_err = 0;
   logic [3:0]  gsw = '0, msw = '0;
   logic        acfail = 0, wpfail = 0, arb_tmo = 0, sysfail = 0, loc_clr = 0;
   logic        loc_pend, loc_l6, loc_l7;
   logic [7:0]  loc_vec;

   int n_chk = 0, n_fail = 0, n_iack = 0;
   logic [2:0] last_lvl = '0;
   logic [15:0] got;

   localparam logic [7:0] EXP_VEC [16] = '{8'd1, 8'd2, 8'd6, 8'd7, 8'd8, 8'd9,
      8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd15, 8'd16, 8'd17, 8'd18, 8'd19};

   always #5 clk = ~clk;

   vme_irq_ack i_vme_irq_ack (
      .clk(clk), .rst_n(rst_n), .vme_irq_n(vme_irq_n),
      .rd_stb(rd_stb), .rd_byte(rd_byte), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .irq_any(irq_any),
      .iack_req(iack_req), .iack_lvl(iack_lvl), .iack_done(iack_done),
      .iack_vec(iack_vec), .host_tmo(host_tmo), .tick(tick), .btn_n(btn_n),
      .bus_err(bus_err), .gsw(gsw), .msw(msw), .acfail(acfail),
      .wpfail(wpfail), .arb_tmo(arb_tmo), .sysfail(sysfail),
      .loc_clr(loc_clr), .loc_pend(loc_pend), .loc_vec(loc_vec),
      .loc_l6(loc_l6), .loc_l7(loc_l7));

   // bus-side responder: answers each acknowledge after one cycle
   initial begin
      forever begin
         @(negedge clk);
         if (iack_done) begin
            iack_done = 1'b0;
         end else if (iack_req) begin
            last_lvl  = iack_lvl;
            n_iack++;
            iack_vec  = 8'hA0 | 8'(iack_lvl);
            iack_done = 1'b1;
         end
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_read(input logic [12:0] a, input logic byt, output logic [15:0] d);
      @(negedge clk);
      rd_stb = 1'b1; rd_addr = a; rd_byte = byt;
      @(negedge clk);
      rd_stb = 1'b0;
      d = 16'hDEAD;
      for (int k = 0; k < 20; k++) begin
         if (rd_ack) begin
            d = rd_data;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic set_evt(input logic [15:0] v);
      host_tmo = v[0]; tick = v[1]; btn_n = ~v[2]; bus_err = v[3];
      gsw = v[7:4]; msw = v[11:8]; acfail = v[12]; wpfail = v[13];
      arb_tmo = v[14]; sysfail = v[15];
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!irq_any && !loc_pend && !loc_l6 && !loc_l7 && !iack_req, "R1 reset", 0, 0);
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h0000, "R2 status empty", got, 0);

      // R9 R10 vector table walk
      for (int i = 0; i < 16; i++) begin
         @(negedge clk); set_evt(16'(1) << i);
         @(negedge clk); set_evt('0);
         @(negedge clk);
         chk(loc_pend && loc_vec == EXP_VEC[i], "R9 local vector", loc_vec, EXP_VEC[i]);
         if (i == 2) chk(loc_l6 && !loc_l7, "R10 button level6", loc_l6, 1);
         if (i == 3) chk(loc_l7 && !loc_l6, "R10 bus error level7", loc_l7, 1);
         loc_clr = 1'b1; @(negedge clk); loc_clr = 1'b0; @(negedge clk);
         chk(!loc_pend, "R11 clear", loc_pend, 0);
      end

      // R10 button rising edge ignored
      btn_n = 1'b0; @(negedge clk); @(negedge clk);
      loc_clr = 1'b1; @(negedge clk); loc_clr = 1'b0;
      btn_n = 1'b1; @(negedge clk); @(negedge clk);
      chk(!loc_pend && !loc_l6, "R10 rising edge ignored", loc_pend, 0);

      // R11 lowest vector first
      @(negedge clk); tick = 1'b1; sysfail = 1'b1;
      @(negedge clk); tick = 1'b0; sysfail = 1'b0;
      @(negedge clk);
      chk(loc_vec == 8'd2, "R11 lowest first", loc_vec, 2);
      loc_clr = 1'b1; @(negedge clk); loc_clr = 1'b0; @(negedge clk);
      chk(loc_pend && loc_vec == 8'd19, "R11 next after clear", loc_vec, 19);
      loc_clr = 1'b1; @(negedge clk); loc_clr = 1'b0; @(negedge clk);

      // R1 R2 R4 R5 R7 level 3 with line held
      vme_irq_n[2] = 1'b0; settle();
      chk(irq_any, "R1 pending", irq_any, 1);
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h0007, "R2 status level3", got, 7);
      host_read(13'h0807, 1'b1, got);
      chk(got == 16'h00A3, "R5 vector level3", got, 16'h00A3);
      chk(last_lvl == 3'd3, "R4 iack level", last_lvl, 3);
      settle();
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h0007, "R7 held after ack", got, 7);
      vme_irq_n[2] = 1'b1; settle();
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h0000 && !irq_any, "R7 cleared", got, 0);

      // R7 released without ack stays pending
      vme_irq_n[4] = 1'b0; settle(); vme_irq_n[4] = 1'b1; settle();
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h000B, "R7 latched without ack", got, 16'h000B);
      host_read(13'h080B, 1'b1, got);
      chk(got == 16'h00A5, "R5 vector level5", got, 16'h00A5);
      settle();
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h0000, "R7 cleared after ack", got, 0);

      // R3 R6 levels 7 and 2
      vme_irq_n[6] = 1'b0; vme_irq_n[1] = 1'b0; settle();
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h000F, "R3 level7 wins", got, 16'h000F);
      host_read(13'h0800 + got[12:0], 1'b1, got);
      chk(got == 16'h00A7, "R6 status plus base", got, 16'h00A7);
      vme_irq_n[6] = 1'b1; settle();
      host_read(13'h0004, 1'b0, got);
      chk(got == 16'h0005, "R3 next level", got, 5);
      host_read(13'h0800 + got[12:0], 1'b1, got);
      chk(got == 16'h00A2, "R6 level2 address", got, 16'h00A2);
      vme_irq_n[1] = 1'b1; settle();

      // R8 rejected reads
      n0 = n_iack;
      host_read(13'h0803, 1'b0, got);
      chk(got == 16'h0000, "R8 word read", got, 0);
      host_read(13'h0804, 1'b1, got);
      chk(got == 16'h0000, "R8 even offset", got, 0);
      host_read(13'h0811, 1'b1, got);
      chk(got == 16'h0000, "R8 beyond level7", got, 0);
      host_read(13'h0100, 1'b1, got);
      chk(got == 16'h0000, "R8 other offset", got, 0);
      chk(n_iack == n0 && !iack_req, "R8 no acknowledge", n_iack - n0, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule